// File: doc/BRIEF.md
# Frame Memory Pixel Packing Controller

This block turns byte-wide pixel accesses into accesses on a 32-bit frame memory word port. Software and imaging logic see each color plane of each frame as 600 rows by 1024 columns of 8-bit pixels. The block stores four horizontally adjacent pixels in one 32-bit word, so a plane is held as 600 rows by 256 word columns. Each frame has three color planes.

A pixel request carries a frame number, a plane, a row, a column and, for writes, a byte. The block decodes the request into a device-local word address, a device select and a byte lane. A write goes out as one word write with a single byte enable set, so the other three pixels of the group are left as they were. A read fetches the whole word, takes the addressed byte out of it and returns that byte with a one-cycle valid pulse.

Two strap inputs report whether the build has one memory device (four frames) or two (eight frames). Exactly one strap is fitted on a valid build. If the strap state is inconsistent, the block flags it and uses four-frame capacity. Requests that fall outside the populated space are refused with an error pulse and never reach memory.

Top module: `fmpack_ctrl`

## Requirements
- R1: While reset is asserted, and until the synchronised release, `px_ready`, `mem_valid`, `rd_valid` and `err_pulse` are all 0. After release the block is idle with `px_ready` = 1.
- R2: For an accepted request, `mem_dev` = 1 for frames 4 to 7 and 0 for frames 0 to 3. `mem_addr` = (((frame mod 4)*3 + plane)*600 + row)*256 + col[9:2].
- R3: An accepted write issues `mem_write` = 1 with exactly one bit of `mem_be` set, namely bit col[1:0]. The pixel byte sits in `mem_wdata` bits [8*col[1:0]+7 : 8*col[1:0]], so pixel 0 of a group is in bits [7:0]. The other lanes are 0.
- R4: An accepted read issues `mem_write` = 0 with `mem_be` = 4'hF. In the cycle after `mem_rvalid`, `rd_valid` pulses for one cycle and `rd_data` equals bits [8*col[1:0]+7 : 8*col[1:0]] of `mem_rdata`.
- R5: While `mem_valid` = 1 and `mem_ready` = 0, every memory request output holds its value. `px_ready` stays 0 from acceptance until the write handshake completes, or until the read data has been returned.
- R6: A request with row ≥ 600 or plane ≥ 3 is refused. `err_pulse` goes high for one cycle in the cycle after acceptance, and no memory request is issued.
- R7: Frames 4 to 7 are refused in the same way as R6 when the capacity is four frames. They are served on device 1 when the capacity is eight frames.
- R8: The straps are decoded as follows (1 = fitted). `strap_four`=1 with `strap_eight`=0 gives four frames. `strap_four`=0 with `strap_eight`=1 gives eight frames. Both straps equal sets `cfg_err` = 1 and gives four frames.
- R9: The memory request of an accepted, in-range pixel request appears on `mem_valid` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_four | input | 1 | Strap fitted on a one-device build |
| strap_eight | input | 1 | Strap fitted on a two-device build |
| cfg_err | output | 1 | Strap state inconsistent |
| px_valid | input | 1 | Pixel request valid |
| px_ready | output | 1 | Block can take a pixel request |
| px_write | input | 1 | 1 = write, 0 = read |
| px_frame | input | 3 | Frame number |
| px_plane | input | 2 | Color plane |
| px_row | input | 10 | Pixel row |
| px_col | input | 10 | Pixel column |
| px_wdata | input | 8 | Pixel byte to write |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_data | output | 8 | Read pixel byte |
| err_pulse | output | 1 | Request refused |
| mem_valid | output | 1 | Word request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | Word request is a write |
| mem_dev | output | 1 | Device select |
| mem_addr | output | 21 | Device-local word address |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Word write data |
| mem_rvalid | input | 1 | Read word response valid |
| mem_rdata | input | 32 | Read word response |

## Verification
The assertions assume three things about the memory side and the straps:
- `mem_rvalid` pulses only while a read is outstanding, and only once per read.
- The straps stay constant while a request is in flight.
- The pixel inputs are known whenever `px_valid` is high.

The bench keeps to these assumptions. Its memory responder answers each read handshake with a single response one cycle later. Strap changes are made only while the block is idle. Stalls are produced only by holding `mem_ready` low.

// File: rtl/fmpack_pkg.sv
package fmpack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fm_state_e;
endpackage

// File: rtl/fmpack_cap.sv
module fmpack_cap (
  input  logic strap_four,
  input  logic strap_eight,
  output logic eight_ok,
  output logic cfg_err
);
  // Valid only when exactly one strap is fitted; otherwise fall back to four frames.
  always_comb begin
    cfg_err  = (strap_four == strap_eight);
    eight_ok = strap_eight && !strap_four;
  end
endmodule

// File: rtl/fmpack_addr.sv
module fmpack_addr #(
  parameter int ROWS       = 600,
  parameter int PLANES     = 3,
  parameter int FRAMES_DEV = 4,
  parameter int WCOLS      = 256,
  parameter int FR_W       = 3,
  parameter int PL_W       = 2,
  parameter int ROW_W      = 10,
  parameter int WC_W       = 8,
  parameter int ADDR_W     = 21
) (
  input  logic [FR_W-1:0]   frame,
  input  logic [PL_W-1:0]   plane,
  input  logic [ROW_W-1:0]  row,
  input  logic [WC_W-1:0]   wcol,
  input  logic              eight_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              dev,
  output logic              bad
);
  logic [FR_W-1:0]   frame_loc;
  logic [ADDR_W-1:0] plane_idx;
  logic [ADDR_W-1:0] row_idx;

  always_comb begin
    dev       = (frame >= FR_W'(FRAMES_DEV));
    frame_loc = dev ? (frame - FR_W'(FRAMES_DEV)) : frame;
    plane_idx = ADDR_W'(frame_loc) * ADDR_W'(PLANES) + ADDR_W'(plane);
    row_idx   = plane_idx * ADDR_W'(ROWS) + ADDR_W'(row);
    addr      = row_idx * ADDR_W'(WCOLS) + ADDR_W'(wcol);
    bad       = ({1'b0, row} >= (ROW_W+1)'(ROWS)) ||
                ({1'b0, plane} >= (PL_W+1)'(PLANES)) ||
                (dev && !eight_ok);
  end
endmodule

// File: rtl/fmpack_lane.sv
module fmpack_lane #(
  parameter int PX_W   = 8,
  parameter int LANES  = 4,
  parameter int LN_W   = 2,
  parameter int WORD_W = 32
) (
  input  logic [LN_W-1:0]   lane,
  input  logic [PX_W-1:0]   px_in,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic [LANES-1:0]  lane_be,
  output logic [PX_W-1:0]   px_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_be[g]                  = (lane == LN_W'(g));
    assign word_out[g*PX_W +: PX_W]    = lane_be[g] ? px_in : '0;
  end

  always_comb begin
    px_out = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane == LN_W'(k)) px_out = word_in[k*PX_W +: PX_W];
    end
  end
endmodule

// File: rtl/fmpack_ctrl.sv
module fmpack_ctrl #(
  parameter int ROWS       = 600,
  parameter int COLS       = 1024,
  parameter int PLANES     = 3,
  parameter int FRAMES_DEV = 4,
  parameter int PX_W       = 8,
  parameter int WORD_W     = 32,
  localparam int LANES     = WORD_W / PX_W,
  localparam int LN_W      = $clog2(LANES),
  localparam int WCOLS     = COLS / LANES,
  localparam int COL_W     = $clog2(COLS),
  localparam int WC_W      = COL_W - LN_W,
  localparam int ROW_W     = $clog2(ROWS),
  localparam int PL_W      = $clog2(PLANES),
  localparam int FR_W      = $clog2(2 * FRAMES_DEV),
  localparam int DEV_WORDS = FRAMES_DEV * PLANES * ROWS * WCOLS,
  localparam int ADDR_W    = $clog2(DEV_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_four,
  input  logic              strap_eight,
  output logic              cfg_err,
  input  logic              px_valid,
  output logic              px_ready,
  input  logic              px_write,
  input  logic [FR_W-1:0]   px_frame,
  input  logic [PL_W-1:0]   px_plane,
  input  logic [ROW_W-1:0]  px_row,
  input  logic [COL_W-1:0]  px_col,
  input  logic [PX_W-1:0]   px_wdata,
  output logic              rd_valid,
  output logic [PX_W-1:0]   rd_data,
  output logic              err_pulse,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic              mem_dev,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [WORD_W-1:0] mem_rdata
);
  import fmpack_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic rs_meta, rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  // Capacity straps
  logic eight_ok;
  fmpack_cap u_cap (
    .strap_four (strap_four),
    .strap_eight(strap_eight),
    .eight_ok   (eight_ok),
    .cfg_err    (cfg_err)
  );

  // Coordinate decode
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_dev, dec_bad;
  fmpack_addr #(
    .ROWS(ROWS), .PLANES(PLANES), .FRAMES_DEV(FRAMES_DEV), .WCOLS(WCOLS),
    .FR_W(FR_W), .PL_W(PL_W), .ROW_W(ROW_W), .WC_W(WC_W), .ADDR_W(ADDR_W)
  ) u_addr (
    .frame   (px_frame),
    .plane   (px_plane),
    .row     (px_row),
    .wcol    (px_col[COL_W-1:LN_W]),
    .eight_ok(eight_ok),
    .addr    (dec_addr),
    .dev     (dec_dev),
    .bad     (dec_bad)
  );

  // Request registers
  fm_state_e         state_q, state_d;
  logic              req_write_q, req_dev_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [LN_W-1:0]   req_lane_q;
  logic [PX_W-1:0]   req_px_q;
  logic              err_q, rdv_q;
  logic [PX_W-1:0]   rdd_q;
  logic              accept, load_en, err_d, rdv_d;

  // Lane packing / unpacking
  logic [WORD_W-1:0] lane_word;
  logic [LANES-1:0]  lane_be;
  logic [PX_W-1:0]   lane_px;
  fmpack_lane #(.PX_W(PX_W), .LANES(LANES), .LN_W(LN_W), .WORD_W(WORD_W)) u_lane (
    .lane    (req_lane_q),
    .px_in   (req_px_q),
    .word_in (mem_rdata),
    .word_out(lane_word),
    .lane_be (lane_be),
    .px_out  (lane_px)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    load_en = 1'b0;
    accept  = px_valid && px_ready;
    err_d   = accept && dec_bad;
    rdv_d   = (state_q == ST_WAIT) && mem_rvalid;
    unique case (state_q)
      ST_IDLE: if (accept && !dec_bad) begin
        load_en = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ:  if (mem_ready) state_d = req_write_q ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (mem_rvalid) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      state_q     <= ST_IDLE;
      req_write_q <= 1'b0;
      req_dev_q   <= 1'b0;
      req_addr_q  <= '0;
      req_lane_q  <= '0;
      req_px_q    <= '0;
      err_q       <= 1'b0;
      rdv_q       <= 1'b0;
      rdd_q       <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      rdv_q   <= rdv_d;
      if (load_en) begin
        req_write_q <= px_write;
        req_dev_q   <= dec_dev;
        req_addr_q  <= dec_addr;
        req_lane_q  <= px_col[LN_W-1:0];
        req_px_q    <= px_wdata;
      end
      if (rdv_d) rdd_q <= lane_px;
    end
  end

  // Outputs
  assign px_ready  = (state_q == ST_IDLE) && rs_n;
  assign mem_valid = (state_q == ST_REQ);
  assign mem_write = req_write_q;
  assign mem_dev   = req_dev_q;
  assign mem_addr  = req_addr_q;
  assign mem_be    = req_write_q ? lane_be : '1;
  assign mem_wdata = lane_word;
  assign rd_valid  = rdv_q;
  assign rd_data   = rdd_q;
  assign err_pulse = err_q;

  // Assertions
  assert_range_R2: assert property (@(posedge clk) disable iff (!rs_n)
    mem_valid |-> ({1'b0, mem_addr} < (ADDR_W+1)'(DEV_WORDS)));

  assert_onehot_be_R3: assert property (@(posedge clk) disable iff (!rs_n)
    (mem_valid && mem_write) |-> ($countones(mem_be) == 1));

  assert_rd_after_resp_R4: assert property (@(posedge clk) disable iff (!rs_n)
    rd_valid |-> $past(mem_rvalid));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rs_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be) &&
                                   $stable(mem_wdata) && $stable(mem_write) && $stable(mem_dev)));

  assert_busy_R5: assert property (@(posedge clk) disable iff (!rs_n)
    mem_valid |-> !px_ready);

  assert_no_req_on_err_R6: assert property (@(posedge clk) disable iff (!rs_n)
    err_pulse |-> !mem_valid);

  assert_fallback_R8: assert property (@(posedge clk) disable iff (!rs_n)
    (px_valid && px_ready && cfg_err && (px_frame >= FR_W'(FRAMES_DEV))) |=> err_pulse);

  assert_issue_R9: assert property (@(posedge clk) disable iff (!rs_n)
    (px_valid && px_ready) |=> (mem_valid || err_pulse));
endmodule

// File: tb/fmpack_ctrl_test.sv
`timescale 1ns/1ps
module fmpack_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap_four, strap_eight, cfg_err;
  logic        px_valid, px_ready, px_write;
  logic [2:0]  px_frame;
  logic [1:0]  px_plane;
  logic [9:0]  px_row, px_col;
  logic [7:0]  px_wdata;
  logic        rd_valid, err_pulse;
  logic [7:0]  rd_data;
  logic        mem_valid, mem_ready, mem_write, mem_dev, mem_rvalid;
  logic [20:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  int req_count = 0;
  logic [20:0] cap_addr;
  logic        cap_dev, cap_write;
  logic [3:0]  cap_be;
  logic [31:0] cap_wdata;

  always #2.5 clk = ~clk;

  fmpack_ctrl uut (
    .clk(clk), .rst_n(rst_n), .strap_four(strap_four), .strap_eight(strap_eight),
    .cfg_err(cfg_err), .px_valid(px_valid), .px_ready(px_ready), .px_write(px_write),
    .px_frame(px_frame), .px_plane(px_plane), .px_row(px_row), .px_col(px_col),
    .px_wdata(px_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .err_pulse(err_pulse),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_dev(mem_dev),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Word content the memory model returns for a given location.
  function automatic logic [31:0] pat(input logic [20:0] a, input logic dv);
    return {a[7:0] ^ 8'h3C, a[15:8] + 8'd7, {dv, 2'b01, a[20:16]}, a[7:0] + 8'd3};
  endfunction

  function automatic logic [20:0] exp_addr(input logic [2:0] f, input logic [1:0] p,
                                           input logic [9:0] r, input logic [9:0] c);
    int v;
    v = ((((int'(f) % 4) * 3 + int'(p)) * 600 + int'(r)) * 256) + int'(c[9:2]);
    return v[20:0];
  endfunction

  // Memory responder: one read response the cycle after a read handshake.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready) begin
        req_count <= req_count + 1;
        cap_addr  <= mem_addr;
        cap_dev   <= mem_dev;
        cap_be    <= mem_be;
        cap_wdata <= mem_wdata;
        cap_write <= mem_write;
        if (!mem_write) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= pat(mem_addr, mem_dev);
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // Vector fields: write, frame, plane, row, col, data, straps{four,eight}, accept
  localparam int NV = 14;
  localparam logic [36:0] VECS [0:NV-1] = '{
    {1'b1, 3'd0, 2'd0, 10'd0,   10'd0,    8'h11, 2'b10, 1'b1},
    {1'b1, 3'd1, 2'd2, 10'd599, 10'd1023, 8'h22, 2'b10, 1'b1},
    {1'b0, 3'd0, 2'd0, 10'd0,   10'd0,    8'h00, 2'b10, 1'b1},
    {1'b0, 3'd3, 2'd1, 10'd300, 10'd514,  8'h00, 2'b10, 1'b1},
    {1'b1, 3'd2, 2'd1, 10'd17,  10'd5,    8'h33, 2'b10, 1'b1},
    {1'b0, 3'd5, 2'd0, 10'd10,  10'd7,    8'h00, 2'b10, 1'b0},
    {1'b0, 3'd5, 2'd0, 10'd10,  10'd7,    8'h00, 2'b01, 1'b1},
    {1'b1, 3'd7, 2'd2, 10'd599, 10'd1022, 8'h44, 2'b01, 1'b1},
    {1'b1, 3'd0, 2'd0, 10'd600, 10'd0,    8'h55, 2'b10, 1'b0},
    {1'b0, 3'd0, 2'd3, 10'd0,   10'd0,    8'h00, 2'b10, 1'b0},
    {1'b0, 3'd6, 2'd1, 10'd1,   10'd1,    8'h00, 2'b11, 1'b0},
    {1'b0, 3'd4, 2'd0, 10'd0,   10'd0,    8'h00, 2'b00, 1'b0},
    {1'b1, 3'd3, 2'd0, 10'd1,   10'd1,    8'h66, 2'b11, 1'b1},
    {1'b0, 3'd1, 2'd2, 10'd599, 10'd1021, 8'h00, 2'b01, 1'b1}
  };

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R5: watchdog expired act=%0d exp=%0d", 50000, 0);
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mem_ready = 1'b1;
    strap_four = 1'b1; strap_eight = 1'b0;
    px_valid = 1'b0; px_write = 1'b0; px_frame = '0; px_plane = '0;
    px_row = '0; px_col = '0; px_wdata = '0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet during reset
    chk(!px_ready && !mem_valid && !rd_valid && !err_pulse, "R1", "outputs in reset",
        {px_ready, mem_valid, rd_valid, err_pulse}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(px_ready == 1'b1, "R1", "px_ready after release", px_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic w, s4, s8, ok, got_err, got_rd, issued;
      logic [2:0] f; logic [1:0] p; logic [9:0] r, c; logic [7:0] d, rdd;
      logic [20:0] ea; logic [31:0] ew;
      int base;
      string tag;
      {w, f, p, r, c, d, s4, s8, ok} = VECS[i];
      got_err = 1'b0; got_rd = 1'b0; rdd = '0;
      @(negedge clk);
      strap_four = s4; strap_eight = s8;
      #1;
      chk(cfg_err == (s4 == s8), "R8", "cfg_err", cfg_err, (s4 == s8));
      px_write = w; px_frame = f; px_plane = p; px_row = r; px_col = c; px_wdata = d;
      px_valid = 1'b1;
      base = req_count;
      @(posedge clk);
      @(negedge clk);
      px_valid = 1'b0;
      issued = mem_valid;
      for (int k = 0; k < 20; k++) begin
        if (err_pulse) got_err = 1'b1;
        if (rd_valid) begin got_rd = 1'b1; rdd = rd_data; end
        if (px_ready && (got_err || got_rd || (w && req_count != base))) break;
        @(negedge clk);
      end
      ea = exp_addr(f, p, r, c);
      if (ok) begin
        chk(issued, "R9", "mem_valid cycle after accept", issued, 1);
        chk(!got_err, "R2", "no error on valid access", got_err, 0);
        chk(cap_addr == ea, "R2", "word address", cap_addr, ea);
        chk(cap_dev == f[2], "R2", "device select", cap_dev, f[2]);
        if (w) begin
          ew = {24'h0, d} << (8 * int'(c[1:0]));
          chk(cap_write && cap_be == (4'b1 << c[1:0]), "R3", "byte enable",
              cap_be, (4'b1 << c[1:0]));
          chk(cap_wdata == ew, "R3", "lane data", cap_wdata, ew);
        end else begin
          ew = pat(ea, f[2]);
          chk(!cap_write && cap_be == 4'hF, "R4", "read enables", cap_be, 4'hF);
          chk(got_rd && rdd == ew[8*int'(c[1:0]) +: 8], "R4", "read byte",
              rdd, ew[8*int'(c[1:0]) +: 8]);
        end
      end else begin
        if (r >= 600 || p >= 3) tag = "R6";
        else if (s4 == s8) tag = "R8";
        else tag = "R7";
        repeat (3) @(negedge clk);
        chk(got_err, tag, "reject pulse", got_err, 1);
        chk(req_count == base, tag, "no memory request", req_count, base);
      end
    end

    // R5: stall holds the request and blocks new pixel requests
    begin
      logic [20:0] held;
      int base;
      @(negedge clk);
      strap_four = 1'b1; strap_eight = 1'b0; mem_ready = 1'b0;
      px_write = 1'b1; px_frame = 3'd2; px_plane = 2'd0; px_row = 10'd42; px_col = 10'd9;
      px_wdata = 8'hA7; px_valid = 1'b1;
      base = req_count;
      @(posedge clk);
      @(negedge clk);
      held = mem_addr;
      px_row = 10'd43;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(mem_valid && !px_ready && mem_addr == held, "R5", "held under stall",
            mem_addr, held);
      end
      px_valid = 1'b0; mem_ready = 1'b1;
      @(negedge clk);
      chk(req_count == base + 1 && px_ready, "R5", "single handshake after stall",
          req_count, base + 1);
      repeat (3) @(negedge clk);
      chk(req_count == base + 1, "R5", "no extra request", req_count, base + 1);
    end

    // R1: reset while a read is pending
    @(negedge clk);
    mem_ready = 1'b0;
    px_write = 1'b0; px_frame = 3'd1; px_row = 10'd5; px_col = 10'd3; px_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    px_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mem_valid && !px_ready, "R1", "reset clears busy request",
        {mem_valid, px_ready}, 0);
    rst_n = 1'b1; mem_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(px_ready && !mem_valid && !rd_valid, "R1", "idle after second release",
        {px_ready, mem_valid, rd_valid}, 3'b100);

    summary();
    $finish;
  end
endmodule